// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Search

This block is the receive path of a serial controller when that controller runs in character-synchronous mode. A one-cycle strobe, `bit_en`, marks each rising edge of the 1x receive clock, and `rxd` is sampled on those strobes. After a search request the block hunts for one or two programmed sync patterns. In the internal case it compares at every bit position. In the external case a pulse on `ext_in` sets the character alignment instead. Once locked, it builds characters of 5 to 8 data bits, with or without a parity bit, and places each one in an output register for the host.

While locked, the block keeps looking for sync, but only at character boundaries. The sync indication is a sticky flag that a status read clears. Parity and overrun errors are sticky flags that only an error-reset strobe clears. Bits arrive least significant first. `char_len` selects the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. `par_even` = 1 selects even parity and 0 selects odd parity.

Top module: `sync_rx_hunt`

## Requirements
- R1: After reset `hunting`=1, and `rx_rdy`, `syndet`, `par_err` and `ovr_err` are 0.
- R2: An accepted search request sets `hunting` and fills the whole shift buffer with ones, so bits received before the request can never complete a sync match.
- R3: While hunting with internal sync, the last received data bits are compared with `sync1` on every bit strobe. In single-sync mode a match sets `syndet` and clears `hunting` on the strobe of the final data bit.
- R4: In double-sync mode (`single_sync`=0) the character right after a `sync1` match must equal `sync2`. If it does, the lock happens on its last bit. If it does not, the block returns to the bitwise search. Sync characters consumed while hunting are not transferred to the host.
- R5: With parity enabled, a hunt match raises `syndet` on the strobe of the parity bit, not on the last data bit.
- R6: A `status_rd` strobe clears `syndet` and leaves `hunting` unchanged. When `syndet` is set and cleared in the same cycle, the set wins.
- R7: While locked, sync is recognised only when a whole aligned character equals the sync pattern (single mode) or completes the `sync1`,`sync2` pair (double mode). A sync pattern that straddles a character boundary is ignored.
- R8: With `ext_sync`=1, internal comparison is off. An `ext_in` high during the hunt locks the block, sets `syndet`, and makes the next bit strobe the first bit of a character. `ext_in` high at any time sets `syndet`.
- R9: While locked and `rx_en`=1, each completed character is written right-aligned to `data_out`, with the unused upper bits zero and no parity bit, and `rx_rdy` is set. A `data_rd` strobe clears `rx_rdy`.
- R10: A character that completes while `rx_rdy` is still 1 replaces the stored one and sets `ovr_err`.
- R11: Parity is checked on every locked character, even when `rx_en`=0. A mismatch sets `par_err`. While `rx_en`=0, `rx_rdy` is held at 0 and `data_out` is not updated.
- R12: An `err_clr` strobe clears `par_err` and `ovr_err`. A new error in the same cycle wins.
- R13: While `sync_mode`=0, `hunt_req`, `bit_en` and `ext_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | Selects the synchronous receive path; 0 freezes the block |
| char_len | input | 2 | Data bits per character: 5 + value |
| par_en | input | 1 | A parity bit follows the data bits |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| single_sync | input | 1 | 1 = one sync character, 0 = a pair |
| ext_sync | input | 1 | Alignment comes from `ext_in` rather than from comparison |
| sync1 | input | 8 | First sync pattern, right-aligned |
| sync2 | input | 8 | Second sync pattern, right-aligned |
| rx_en | input | 1 | Allows transfer to the host register |
| bit_en | input | 1 | One-cycle strobe per receive-clock rising edge |
| rxd | input | 1 | Serial data |
| ext_in | input | 1 | External sync indication |
| hunt_req | input | 1 | Strobe: start searching for sync |
| err_clr | input | 1 | Strobe: clear the error flags |
| status_rd | input | 1 | Strobe: status read, clears `syndet` |
| data_rd | input | 1 | Strobe: host read of `data_out` |
| data_out | output | 8 | Last transferred character |
| rx_rdy | output | 1 | A character is waiting |
| syndet | output | 1 | Sticky sync-found flag |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun |
| hunting | output | 1 | Searching for sync |

## Verification
A wrong bit counter or a wrong phase shows up within one character time. The visible symptoms are a `syndet` that rises one bit early or late, shifted bits in `data_out`, or an `rx_rdy` that appears while the block is still hunting. A stale shift buffer shows only when a search request arrives in the middle of a sync pattern, so the bench sends exactly that sequence. Flag priority errors show on the next clock edge after two strobes coincide.

// File: rtl/syrx_pkg.sv
package syrx_pkg;
  localparam int CHAR_MAX = 8;
  localparam int SH_W     = CHAR_MAX + 1;
  localparam int CNT_W    = $clog2(SH_W + 1);

  typedef enum logic [1:0] {PH_HUNT1, PH_HUNT2, PH_LOCK} phase_t;

  // data bits plus optional parity bit
  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] len, input logic pen);
    return CNT_W'(5) + CNT_W'(len) + CNT_W'(pen);
  endfunction

  function automatic logic [CHAR_MAX-1:0] data_mask(input logic [1:0] len);
    return {CHAR_MAX{1'b1}} >> (2'd3 - len);
  endfunction

  // newest frame, oldest bit in position 0
  function automatic logic [SH_W-1:0] frame_win(input logic [SH_W-1:0] sh,
                                                 input logic [CNT_W-1:0] fb);
    return sh >> (SH_W - int'(fb));
  endfunction

  function automatic logic [CHAR_MAX-1:0] char_of(input logic [SH_W-1:0] win,
                                                   input logic [1:0] len);
    return win[CHAR_MAX-1:0] & data_mask(len);
  endfunction

  function automatic logic parity_ok(input logic [SH_W-1:0] win, input logic [1:0] len,
                                     input logic even);
    logic x;
    x = (^char_of(win, len)) ^ win[5 + int'(len)];
    return x == !even;
  endfunction
endpackage

// File: rtl/syrx_shift.sv
module syrx_shift import syrx_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            preload,
  input  logic            rxd,
  output logic [SH_W-1:0] sh_next
);
  logic [SH_W-1:0] sh_q;

  assign sh_next = {rxd, sh_q[SH_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '1;
    else if (preload)  sh_q <= '1;
    else if (shift_en) sh_q <= sh_next;
  end
endmodule

// File: rtl/syrx_seq.sv
module syrx_seq import syrx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_go,
  input  logic                hunt_go,
  input  logic                ext_mode,
  input  logic                ext_in,
  input  logic                single_sync,
  input  logic [CNT_W-1:0]    fbits,
  input  logic [CHAR_MAX-1:0] chr_nx,
  input  logic [CHAR_MAX-1:0] s1m,
  input  logic [CHAR_MAX-1:0] s2m,
  output logic                hunting,
  output logic                xfer_evt,
  output logic                lock_evt,
  output logic                bnd_hit
);
  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_s1_q;

  logic last_bit, frame_end, is_s1, is_s2, hunt_hit1, pair_done, ext_lock;

  assign last_bit  = (cnt_q == (fbits - CNT_W'(1)));
  assign frame_end = bit_go && (ph_q != PH_HUNT1) && last_bit;
  assign is_s1     = (chr_nx == s1m);
  assign is_s2     = (chr_nx == s2m);
  assign hunt_hit1 = bit_go && (ph_q == PH_HUNT1) && !ext_mode && is_s1;
  assign pair_done = frame_end && (ph_q == PH_HUNT2) && is_s2;
  assign ext_lock  = ext_mode && ext_in && (ph_q != PH_LOCK);

  assign lock_evt = !hunt_go && ((hunt_hit1 && single_sync) || pair_done || ext_lock);
  assign xfer_evt = !hunt_go && frame_end && (ph_q == PH_LOCK);
  assign bnd_hit  = xfer_evt && !ext_mode &&
                    (single_sync ? is_s1 : (prev_s1_q && is_s2));
  assign hunting  = (ph_q != PH_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_HUNT1; cnt_q <= '0; prev_s1_q <= 1'b0;
    end else if (hunt_go) begin
      ph_q <= PH_HUNT1; cnt_q <= '0; prev_s1_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_HUNT1: begin
          if (ext_lock) begin
            ph_q <= PH_LOCK; cnt_q <= '0;
          end else if (hunt_hit1) begin
            ph_q <= single_sync ? PH_LOCK : PH_HUNT2; cnt_q <= '0;
          end
        end
        PH_HUNT2: begin
          if (ext_lock) begin
            ph_q <= PH_LOCK; cnt_q <= '0;
          end else if (bit_go) begin
            if (last_bit) begin
              ph_q <= is_s2 ? PH_LOCK : PH_HUNT1; cnt_q <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          if (bit_go) begin
            if (last_bit) begin
              cnt_q <= '0; prev_s1_q <= is_s1;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/syrx_flags.sv
module syrx_flags import syrx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_evt,
  input  logic                rx_en,
  input  logic [CHAR_MAX-1:0] chr_nx,
  input  logic                par_bad,
  input  logic                syn_set,
  input  logic                data_rd,
  input  logic                status_rd,
  input  logic                err_clr,
  output logic [CHAR_MAX-1:0] data_out,
  output logic                rx_rdy,
  output logic                syndet,
  output logic                par_err,
  output logic                ovr_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0; rx_rdy <= 1'b0; syndet <= 1'b0;
      par_err  <= 1'b0; ovr_err <= 1'b0;
    end else begin
      if (xfer_evt && rx_en) data_out <= chr_nx;

      if (!rx_en)        rx_rdy <= 1'b0;
      else if (xfer_evt) rx_rdy <= 1'b1;
      else if (data_rd)  rx_rdy <= 1'b0;

      if (xfer_evt && rx_en && rx_rdy) ovr_err <= 1'b1;
      else if (err_clr)                ovr_err <= 1'b0;

      if (xfer_evt && par_bad) par_err <= 1'b1;
      else if (err_clr)        par_err <= 1'b0;

      if (syn_set)        syndet <= 1'b1;
      else if (status_rd) syndet <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_rx_hunt.sv
module sync_rx_hunt import syrx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_mode,
  input  logic [1:0]          char_len,
  input  logic                par_en,
  input  logic                par_even,
  input  logic                single_sync,
  input  logic                ext_sync,
  input  logic [CHAR_MAX-1:0] sync1,
  input  logic [CHAR_MAX-1:0] sync2,
  input  logic                rx_en,
  input  logic                bit_en,
  input  logic                rxd,
  input  logic                ext_in,
  input  logic                hunt_req,
  input  logic                err_clr,
  input  logic                status_rd,
  input  logic                data_rd,
  output logic [CHAR_MAX-1:0] data_out,
  output logic                rx_rdy,
  output logic                syndet,
  output logic                par_err,
  output logic                ovr_err,
  output logic                hunting
);
  // named internal events
  logic                bit_go, hunt_go, ext_mode;
  logic [CNT_W-1:0]    fbits;
  logic [SH_W-1:0]     sh_next, win_nx;
  logic [CHAR_MAX-1:0] chr_nx, s1m, s2m;
  logic                par_bad, xfer_evt, lock_evt, bnd_hit, syn_set;

  assign bit_go   = bit_en && sync_mode;
  assign hunt_go  = hunt_req && sync_mode;
  assign ext_mode = ext_sync && sync_mode;
  assign fbits    = frame_bits(char_len, par_en);
  assign win_nx   = frame_win(sh_next, fbits);
  assign chr_nx   = char_of(win_nx, char_len);
  assign s1m      = sync1 & data_mask(char_len);
  assign s2m      = sync2 & data_mask(char_len);
  assign par_bad  = par_en && !parity_ok(win_nx, char_len, par_even);
  assign syn_set  = lock_evt || bnd_hit || (ext_mode && ext_in);

  syrx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_go), .preload(hunt_go),
    .rxd(rxd), .sh_next(sh_next)
  );

  syrx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bit_go(bit_go), .hunt_go(hunt_go),
    .ext_mode(ext_mode), .ext_in(ext_in), .single_sync(single_sync),
    .fbits(fbits), .chr_nx(chr_nx), .s1m(s1m), .s2m(s2m),
    .hunting(hunting), .xfer_evt(xfer_evt), .lock_evt(lock_evt), .bnd_hit(bnd_hit)
  );

  syrx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .xfer_evt(xfer_evt), .rx_en(rx_en),
    .chr_nx(chr_nx), .par_bad(par_bad), .syn_set(syn_set),
    .data_rd(data_rd), .status_rd(status_rd), .err_clr(err_clr),
    .data_out(data_out), .rx_rdy(rx_rdy), .syndet(syndet),
    .par_err(par_err), .ovr_err(ovr_err)
  );
endmodule

// File: rtl/syrx_chk.sv
module syrx_chk import syrx_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_mode,
  input logic [1:0]          char_len,
  input logic                rx_en,
  input logic                hunt_req,
  input logic                err_clr,
  input logic                status_rd,
  input logic                xfer_evt,
  input logic                syn_set,
  input logic [CHAR_MAX-1:0] data_out,
  input logic                rx_rdy,
  input logic                syndet,
  input logic                par_err,
  input logic                ovr_err,
  input logic                hunting
);
  assert_hunt_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_req && sync_mode) |=> hunting);

  assert_lock_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hunting) |-> syndet);

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !syn_set) |=> !syndet);

  assert_rdy_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(xfer_evt));

  assert_right_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && rx_en) |=> ((data_out & ~data_mask($past(char_len))) == '0));

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && rx_en && rx_rdy) |=> ovr_err);

  assert_rdy_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_rdy);

  assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !xfer_evt) |=> (!ovr_err && !par_err));

  assert_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> $stable(hunting));
endmodule

bind sync_rx_hunt syrx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .char_len(char_len),
  .rx_en(rx_en), .hunt_req(hunt_req), .err_clr(err_clr), .status_rd(status_rd),
  .xfer_evt(xfer_evt), .syn_set(syn_set), .data_out(data_out), .rx_rdy(rx_rdy),
  .syndet(syndet), .par_err(par_err), .ovr_err(ovr_err), .hunting(hunting)
);

// File: tb/sim_sync_rx_hunt.sv
`timescale 1ns/1ps
module sim_sync_rx_hunt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b1, par_en = 1'b0, par_even = 1'b0, single_sync = 1'b1, ext_sync = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] sync1 = 8'h16, sync2 = 8'h9A;
  logic rx_en = 1'b1, bit_en = 1'b0, rxd = 1'b1, ext_in = 1'b0;
  logic hunt_req = 1'b0, err_clr = 1'b0, status_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] data_out;
  logic rx_rdy, syndet, par_err, ovr_err, hunting;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  localparam int S_HUNT = 0, S_STAT = 1, S_DRD = 2, S_ERR = 3, S_EXT = 4;

  always #2.5 clk = ~clk;

  sync_rx_hunt u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .single_sync(single_sync), .ext_sync(ext_sync),
    .sync1(sync1), .sync2(sync2), .rx_en(rx_en), .bit_en(bit_en), .rxd(rxd),
    .ext_in(ext_in), .hunt_req(hunt_req), .err_clr(err_clr), .status_rd(status_rd),
    .data_rd(data_rd), .data_out(data_out), .rx_rdy(rx_rdy), .syndet(syndet),
    .par_err(par_err), .ovr_err(ovr_err), .hunting(hunting)
  );

  function automatic logic [7:0] low_bits(input logic [7:0] v, input int n);
    logic [7:0] m;
    m = 8'((9'd1 << n) - 9'd1);
    return v & m;
  endfunction

  function automatic logic par_of(input logic [7:0] v, input int n, input logic even);
    logic ones_odd;
    ones_odd = ^low_bits(v, n);
    return even ? ones_odd : !ones_odd;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rxd = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] v, input int n, input logic pe,
                           input logic ev, input logic fl);
    for (int i = 0; i < n; i++) send_bit(v[i]);
    if (pe) send_bit(par_of(v, n, ev) ^ fl);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    send_char(v, n, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      S_HUNT: hunt_req = 1'b1;
      S_STAT: status_rd = 1'b1;
      S_DRD:  data_rd = 1'b1;
      S_ERR:  err_clr = 1'b1;
      default: ext_in = 1'b1;
    endcase
    @(negedge clk);
    hunt_req = 1'b0; status_rd = 1'b0; data_rd = 1'b0; err_clr = 1'b0; ext_in = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] c, keep;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", hunting, 1, "hunting");
    check("R1", {rx_rdy, syndet, par_err, ovr_err}, 0, "flags");

    // R3 single sync, 8 bits, no parity
    strobe(S_HUNT);
    send_bits(8'h00, 8);
    check("R3", hunting, 1, "still hunting on zeros");
    send_bits(8'h16, 7);
    check("R3", syndet, 0, "no syndet before last bit");
    send_bit(1'b0);
    check("R3", syndet, 1, "syndet at last bit");
    check("R3", hunting, 0, "locked");

    // R9 transfer and read
    c = 8'($urandom);
    send_char(c, 8, 0, 0, 0);
    check("R9", data_out, c, "data 8b");
    check("R9", rx_rdy, 1, "rx_rdy set");
    strobe(S_DRD);
    check("R9", rx_rdy, 0, "rx_rdy cleared by read");

    // R6 status read
    strobe(S_STAT);
    check("R6", syndet, 0, "syndet cleared");
    check("R6", hunting, 0, "no rehunt after status read");

    // R7 straddling pattern ignored, R10 overrun
    send_bits(8'h00, 4); send_bits(8'h16, 8); send_bits(8'h00, 4);
    check("R7", syndet, 0, "misaligned sync ignored");
    check("R10", ovr_err, 1, "overrun");
    check("R10", data_out, 8'h01, "newer char kept");
    send_bits(8'h16, 8);
    check("R7", syndet, 1, "aligned sync after lock");
    strobe(S_STAT); strobe(S_DRD); strobe(S_ERR);
    check("R12", ovr_err, 0, "ovr cleared");

    // R2 preload blocks stale match
    send_bits(8'h16, 7);
    strobe(S_HUNT);
    check("R2", hunting, 1, "hunting after request");
    send_bit(1'b0);
    check("R2", syndet, 0, "no stale match");
    check("R2", hunting, 1, "still hunting");

    // R4 double sync
    single_sync = 1'b0;
    strobe(S_HUNT);
    send_bits(8'h00, 8);
    send_bits(8'h16, 8);
    check("R4", {hunting, syndet}, 2'b10, "after sync1 only");
    send_bits(8'h00, 8);
    check("R4", {hunting, syndet}, 2'b10, "pair broken");
    send_bits(8'h16, 8);
    send_bits(8'h9A, 8);
    check("R4", {hunting, syndet}, 2'b01, "pair locked");
    check("R4", rx_rdy, 0, "sync chars not transferred");
    strobe(S_STAT);

    // R5 parity in hunt, 7-bit even
    single_sync = 1'b1; char_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
    strobe(S_HUNT);
    send_bits(8'h00, 8);
    send_bits(8'h16, 7);
    check("R5", syndet, 0, "not at last data bit");
    send_bit(par_of(8'h16, 7, 1'b1));
    check("R5", syndet, 1, "at parity bit");

    c = 8'($urandom) & 8'h7F;
    send_char(c, 7, 1, 1, 0);
    check("R9", data_out, c, "7-bit right aligned");
    check("R11", par_err, 0, "good parity");
    strobe(S_DRD);
    c = 8'($urandom) & 8'h7F;
    send_char(c, 7, 1, 1, 1);
    check("R11", par_err, 1, "bad parity");
    check("R9", data_out, c, "data with bad parity");
    keep = c;
    strobe(S_DRD); strobe(S_ERR);
    check("R12", par_err, 0, "par cleared");

    // R11 receive disabled
    rx_en = 1'b0;
    send_char(8'($urandom) & 8'h7F, 7, 1, 1, 1);
    check("R11", par_err, 1, "parity checked while disabled");
    check("R11", rx_rdy, 0, "no rx_rdy while disabled");
    check("R11", data_out, keep, "data held while disabled");
    rx_en = 1'b1; strobe(S_ERR);

    // R9 5-bit
    char_len = 2'd0; par_en = 1'b0;
    strobe(S_STAT); strobe(S_HUNT);
    send_bits(8'h00, 5); send_bits(8'h16, 5);
    check("R3", syndet, 1, "5-bit lock");
    c = 8'($urandom);
    send_bits(c, 5);
    check("R9", data_out, low_bits(c, 5), "5-bit upper zeros");
    strobe(S_DRD);

    // R8 external sync
    char_len = 2'd3; ext_sync = 1'b1;
    strobe(S_STAT); strobe(S_HUNT);
    send_bits(8'h16, 8);
    check("R8", {hunting, syndet}, 2'b10, "internal compare off");
    strobe(S_EXT);
    check("R8", {hunting, syndet}, 2'b01, "external lock");
    c = 8'($urandom);
    send_bits(c, 8);
    check("R8", data_out, c, "char after external lock");
    strobe(S_DRD);

    // R13 ignored when sync mode is off
    ext_sync = 1'b0; sync_mode = 1'b0;
    strobe(S_HUNT);
    send_bits(8'hFF, 3);
    check("R13", hunting, 0, "hunt request ignored");
    sync_mode = 1'b1;
    c = 8'($urandom);
    send_bits(c, 8);
    check("R13", data_out, c, "alignment kept");

    // random configurations
    for (int it = 0; it < 20; it++) begin
      logic [1:0] l;
      logic pe, ev;
      int n;
      l = 2'($urandom); pe = 1'($urandom); ev = 1'($urandom); n = 5 + int'(l);
      char_len = l; par_en = pe; par_even = ev; single_sync = 1'b1;
      strobe(S_ERR); strobe(S_STAT); strobe(S_DRD); strobe(S_HUNT);
      send_bits(8'h00, n);
      send_char(8'h16, n, pe, ev, 1'b0);
      check("R3", syndet, 1, "random lock");
      strobe(S_STAT);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        logic fl;
        d = 8'($urandom); fl = (($urandom % 4) == 0);
        send_char(d, n, pe, ev, fl);
        check("R9", data_out, low_bits(d, n), "random data");
        check("R11", par_err, pe & fl, "random parity");
        strobe(S_DRD); strobe(S_ERR);
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule